// File: doc/BRIEF.md
# Audio Coprocessor Address Decoder with Boot ROM Overlay

This block sits between a byte-wide CPU bus and everything that CPU can reach in a 64 KB audio address space. For each access it picks one target. Most addresses go to external RAM. A small boot ROM can be laid over the top 64 bytes. A page of sixteen control addresses at 0xF0 to 0xFF holds local registers and passes accesses on to an external timer block. One address pair inside that page forms an indirect window into a 128-entry sound register file.

The decoder holds a small set of local state: the mapping control (the timer enables and the ROM map flag), the sound register index and four communication port bytes. Timers, the sound engine and the RAM array are outside the block. It reaches them through select and strobe ports. The CPU side is decoded in a single cycle: selects, strobes and read data follow the address in the same cycle, and local registers update on the next clock edge. If read and write strobes are raised together, the write wins.

Top module: `aud_io_decoder`

## Requirements
- R1: Addresses below 0xF0, plus 0xF8 and 0xF9, select RAM: `ram_sel` is high, `ram_addr` equals the CPU address, `ram_we` follows the write strobe, and a read returns `ram_rdata`.
- R2: While the ROM is mapped, a read in 0xFFC0 to 0xFFFF raises `rom_sel` with `rom_addr` equal to the low 6 address bits and returns `rom_rdata`. While it is unmapped, the same read goes to RAM.
- R3: A write in 0xFFC0 to 0xFFFF always goes to RAM, mapped or not. Bytes written while the ROM is mapped are read back from RAM once it is unmapped.
- R4: A write to 0xF1 loads the timer enables `tmr_en` from data bits 2..0 and the ROM map flag from bit 7 (1 = mapped). Reads of 0xF1 return 0.
- R5: Addresses 0xF4 to 0xF7 are four read/write port bytes. A write to 0xF1 with bit 4 set clears 0xF4 and 0xF5. With bit 5 set, it clears 0xF6 and 0xF7. Other port bytes are unchanged.
- R6: 0xF2 is a read/write 8-bit index. A read of 0xF3 raises `snd_rd` with `snd_idx` equal to the index's low 7 bits and returns `snd_rdata`.
- R7: A write to 0xF3 raises `snd_wr` only when the full 8-bit index is below 128. Otherwise no strobe leaves the block and only `io_sel` is high.
- R8: A write to 0xF0 changes no state, and reads of 0xF0 return 0.
- R9: Reads of 0xFD to 0xFF raise `tmr_rd` and return `tmr_rdata`. Writes to 0xFA to 0xFF raise `tmr_wr` with `tmr_wdata`. `tmr_reg` is the address minus 0xFA. Reads of 0xFA to 0xFC return 0 and raise only `io_sel`.
- R10: After reset the timer enables, the index and all four port bytes are 0, and the ROM is mapped.
- R11: Exactly one of `ram_sel`, `rom_sel`, `io_sel`, `snd_rd|snd_wr` and `tmr_rd|tmr_wr` is high during any strobe, and none is high when the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data, same cycle |
| ram_sel | output | 1 | RAM selected |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| rom_sel | output | 1 | Boot ROM selected |
| rom_addr | output | 6 | Boot ROM byte address |
| rom_rdata | input | 8 | Boot ROM data |
| io_sel | output | 1 | Local register page selected |
| snd_rd | output | 1 | Sound register read strobe |
| snd_wr | output | 1 | Sound register write strobe |
| snd_idx | output | 7 | Sound register index |
| snd_wdata | output | 8 | Sound register write data |
| snd_rdata | input | 8 | Sound register read data |
| tmr_en | output | 3 | Timer enables |
| tmr_rd | output | 1 | Counter read (clear-on-read) strobe |
| tmr_wr | output | 1 | Timer write strobe |
| tmr_reg | output | 3 | Timer register number (address minus 0xFA) |
| tmr_wdata | output | 8 | Timer write data |
| tmr_rdata | input | 8 | Timer read data |

## Verification
The ROM top region is written and read with the overlay mapped, then unmapped, then mapped again. This separates a decoder that blocks writes, or lets them through to ROM, from one that shadows writes into RAM. The index register is loaded with 0x05, 0x7F, 0x80 and 0x85. This separates masking on reads from dropping on writes, and puts both index values next to the 128 boundary. The port bytes are loaded with distinct values before each clear bit is written, so a clear that hits the wrong pair shows up. Each of the sixteen control page offsets is also probed in both directions against a behavioural model.

// File: rtl/aud_io_pkg.sv
package aud_io_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int TMR_N   = 3;
  localparam int PORT_N  = 4;

  // Access target picked by the decoder for one bus strobe.
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_RAM  = 3'd1,
    TGT_ROM  = 3'd2,
    TGT_IO   = 3'd3,
    TGT_SND  = 3'd4,
    TGT_TMR  = 3'd5
  } tgt_e;

  // Offsets inside the control page; position is behaviour.
  localparam logic [3:0] OFF_TEST = 4'h0;
  localparam logic [3:0] OFF_CTRL = 4'h1;
  localparam logic [3:0] OFF_IDX  = 4'h2;
  localparam logic [3:0] OFF_DATA = 4'h3;
  localparam logic [3:0] OFF_PORT = 4'h4;
  localparam logic [3:0] OFF_TMR  = 4'hA;

  // Control byte bit positions.
  localparam int CTL_CLR_LO = 4;
  localparam int CTL_CLR_HI = 5;
  localparam int CTL_MAP    = 7;
endpackage

// File: rtl/aio_decode.sv
module aio_decode
  import aud_io_pkg::*;
#(
  parameter int ROM_BYTES = 64,
  parameter int SND_REGS  = 128
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              rom_map,
  input  logic [DATA_W-1:0] idx,
  output tgt_e              tgt
);
  localparam logic [ADDR_W-1:0] ROM_BASE = ADDR_W'((1 << ADDR_W) - ROM_BYTES);
  localparam logic [DATA_W:0]   SND_LIM  = (DATA_W+1)'(SND_REGS);

  logic in_page;
  logic idx_ok;

  assign in_page = (addr[ADDR_W-1:4] == 12'h00F);
  assign idx_ok  = ({1'b0, idx} < SND_LIM);

  always_comb begin
    tgt = TGT_NONE;
    if (rd || wr) begin
      if (in_page) begin
        case (addr[3:0])
          4'h3:             tgt = (!wr || idx_ok) ? TGT_SND : TGT_IO;
          4'h8, 4'h9:       tgt = TGT_RAM;
          4'hA, 4'hB, 4'hC: tgt = wr ? TGT_TMR : TGT_IO;
          4'hD, 4'hE, 4'hF: tgt = TGT_TMR;
          default:          tgt = TGT_IO;
        endcase
      end else if (rom_map && !wr && (addr >= ROM_BASE)) begin
        tgt = TGT_ROM;
      end else begin
        tgt = TGT_RAM;
      end
    end
  end
endmodule

// File: rtl/aio_regs.sv
module aio_regs
  import aud_io_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [3:0]                  off,
  input  logic [DATA_W-1:0]           wdata,
  output logic [TMR_N-1:0]            en,
  output logic                        rom_map,
  output logic [DATA_W-1:0]           idx,
  output logic [PORT_N-1:0][DATA_W-1:0] ports
);
  logic                          wr_ctrl, wr_idx;
  logic [TMR_N-1:0]              en_d;
  logic                          map_d;
  logic [DATA_W-1:0]             idx_d;
  logic [PORT_N-1:0][DATA_W-1:0] ports_d;
  logic [PORT_N-1:0]             port_ce;
  logic                          unused_ctl;

  assign wr_ctrl    = wr_en && (off == OFF_CTRL);
  assign wr_idx     = wr_en && (off == OFF_IDX);
  assign unused_ctl = ^{wdata[6], wdata[3]};

  always_comb begin
    en_d  = wr_ctrl ? wdata[TMR_N-1:0] : en;
    map_d = wr_ctrl ? wdata[CTL_MAP]   : rom_map;
    idx_d = wr_idx  ? wdata            : idx;
  end

  for (genvar p = 0; p < PORT_N; p++) begin : g_port
    logic hit, clr;
    assign hit = wr_en && (off == OFF_PORT + 4'(p));
    assign clr = wr_ctrl && wdata[CTL_CLR_LO + p/2];
    assign port_ce[p] = hit || clr;
    always_comb ports_d[p] = hit ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ports[p] <= '0;
      else if (port_ce[p]) ports[p] <= ports_d[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= '0;
      rom_map <= 1'b1;
      idx     <= '0;
    end else begin
      if (wr_ctrl) begin
        en      <= en_d;
        rom_map <= map_d;
      end
      if (wr_idx) idx <= idx_d;
    end
  end

  assert_port_clear_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[CTL_CLR_LO]) |=> (ports[0] == '0 && ports[1] == '0));
  assert_port_clear_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[CTL_CLR_HI]) |=> (ports[2] == '0 && ports[3] == '0));
  assert_test_reg_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == OFF_TEST) |=>
      ($stable(en) && $stable(rom_map) && $stable(idx) && $stable(ports)));
endmodule

// File: rtl/aio_rdmux.sv
module aio_rdmux
  import aud_io_pkg::*;
(
  input  tgt_e                          tgt,
  input  logic                          wr,
  input  logic [3:0]                    off,
  input  logic [DATA_W-1:0]             idx,
  input  logic [PORT_N-1:0][DATA_W-1:0] ports,
  input  logic [DATA_W-1:0]             ram_rdata,
  input  logic [DATA_W-1:0]             rom_rdata,
  input  logic [DATA_W-1:0]             snd_rdata,
  input  logic [DATA_W-1:0]             tmr_rdata,
  output logic [DATA_W-1:0]             rdata
);
  logic [DATA_W-1:0] io_data;

  always_comb begin
    io_data = '0;
    if (off == OFF_IDX) io_data = idx;
    else if (off[3:2] == 2'b01) io_data = ports[off[1:0]];
  end

  always_comb begin
    rdata = '0;
    if (!wr) begin
      case (tgt)
        TGT_RAM: rdata = ram_rdata;
        TGT_ROM: rdata = rom_rdata;
        TGT_IO:  rdata = io_data;
        TGT_SND: rdata = snd_rdata;
        TGT_TMR: rdata = tmr_rdata;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/aud_io_decoder.sv
module aud_io_decoder
  import aud_io_pkg::*;
#(
  parameter int ROM_BYTES = 64,
  parameter int SND_REGS  = 128,
  localparam int ROM_AW   = $clog2(ROM_BYTES),
  localparam int SND_AW   = $clog2(SND_REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        cpu_addr,
  input  logic [7:0]         cpu_wdata,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  output logic [7:0]         cpu_rdata,
  output logic               ram_sel,
  output logic               ram_we,
  output logic [15:0]        ram_addr,
  output logic [7:0]         ram_wdata,
  input  logic [7:0]         ram_rdata,
  output logic               rom_sel,
  output logic [ROM_AW-1:0]  rom_addr,
  input  logic [7:0]         rom_rdata,
  output logic               io_sel,
  output logic               snd_rd,
  output logic               snd_wr,
  output logic [SND_AW-1:0]  snd_idx,
  output logic [7:0]         snd_wdata,
  input  logic [7:0]         snd_rdata,
  output logic [2:0]         tmr_en,
  output logic               tmr_rd,
  output logic               tmr_wr,
  output logic [2:0]         tmr_reg,
  output logic [7:0]         tmr_wdata,
  input  logic [7:0]         tmr_rdata
);
  localparam logic [15:0] ROM_BASE = 16'((1 << 16) - ROM_BYTES);

  logic [1:0]                    rst_sync;
  logic                          rst_n_int;
  tgt_e                          tgt;
  logic                          rom_map;
  logic [DATA_W-1:0]             idx;
  logic [PORT_N-1:0][DATA_W-1:0] ports;
  logic                          io_wr;
  logic [3:0]                    off_m;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  aio_decode #(.ROM_BYTES(ROM_BYTES), .SND_REGS(SND_REGS)) u_dec (
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
    .rom_map(rom_map), .idx(idx), .tgt(tgt)
  );

  assign io_wr = cpu_wr && (tgt == TGT_IO);

  aio_regs u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr_en(io_wr), .off(cpu_addr[3:0]),
    .wdata(cpu_wdata), .en(tmr_en), .rom_map(rom_map), .idx(idx), .ports(ports)
  );

  aio_rdmux u_mux (
    .tgt(tgt), .wr(cpu_wr), .off(cpu_addr[3:0]), .idx(idx), .ports(ports),
    .ram_rdata(ram_rdata), .rom_rdata(rom_rdata), .snd_rdata(snd_rdata),
    .tmr_rdata(tmr_rdata), .rdata(cpu_rdata)
  );

  assign off_m     = cpu_addr[3:0] - OFF_TMR;
  assign ram_sel   = (tgt == TGT_RAM);
  assign ram_we    = ram_sel && cpu_wr;
  assign ram_addr  = cpu_addr;
  assign ram_wdata = cpu_wdata;
  assign rom_sel   = (tgt == TGT_ROM);
  assign rom_addr  = cpu_addr[ROM_AW-1:0];
  assign io_sel    = (tgt == TGT_IO);
  assign snd_rd    = (tgt == TGT_SND) && !cpu_wr;
  assign snd_wr    = (tgt == TGT_SND) && cpu_wr;
  assign snd_idx   = idx[SND_AW-1:0];
  assign snd_wdata = cpu_wdata;
  assign tmr_rd    = (tgt == TGT_TMR) && !cpu_wr;
  assign tmr_wr    = (tgt == TGT_TMR) && cpu_wr;
  assign tmr_reg   = off_m[2:0];
  assign tmr_wdata = cpu_wdata;

  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cpu_rd || cpu_wr) |->
      $countones({ram_sel, rom_sel, io_sel, snd_rd | snd_wr, tmr_rd | tmr_wr}) == 1);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(cpu_rd || cpu_wr) |-> !(ram_sel || rom_sel || io_sel || snd_rd || snd_wr || tmr_rd || tmr_wr));
  assert_rom_write_ram_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cpu_wr && cpu_addr >= ROM_BASE) |-> (ram_we && !rom_sel));
  assert_snd_write_range_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    snd_wr |-> ({1'b0, idx} < 9'(SND_REGS)));
  assert_tmr_en_load_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cpu_wr && cpu_addr == 16'h00F1) |=> (tmr_en == $past(cpu_wdata[2:0])));
endmodule

// File: tb/aud_io_decoder_test.sv
module aud_io_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_rdata;
  logic        ram_sel, ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic        rom_sel;
  logic [5:0]  rom_addr;
  logic [7:0]  rom_rdata;
  logic        io_sel, snd_rd, snd_wr;
  logic [6:0]  snd_idx;
  logic [7:0]  snd_wdata, snd_rdata;
  logic [2:0]  tmr_en;
  logic        tmr_rd, tmr_wr;
  logic [2:0]  tmr_reg;
  logic [7:0]  tmr_wdata, tmr_rdata;

  always #2 clk = ~clk;

  aud_io_decoder uut (.*);

  // External environment: small hashed RAM, computed ROM, sound and timer data.
  logic [7:0] ext_mem [0:255];
  function automatic logic [7:0] hsh(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction
  always @(posedge clk) if (ram_we) ext_mem[hsh(ram_addr)] <= ram_wdata;
  assign ram_rdata = ext_mem[hsh(ram_addr)];
  assign rom_rdata = {2'b10, rom_addr} ^ 8'h15;
  assign snd_rdata = {1'b0, snd_idx} ^ 8'h5A;
  assign tmr_rdata = {5'b01100, tmr_reg};

  // Reference model state.
  int         checks = 0, fails = 0;
  logic [7:0] ref_mem [int];
  bit         ref_map;
  logic [2:0] ref_en;
  logic [7:0] ref_idx;
  logic [7:0] ref_port [4];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // 1 RAM, 2 ROM, 3 local page, 4 sound, 5 timer
  function automatic int exp_tgt(input logic [15:0] a, input bit w);
    if (a[15:4] == 12'h00F) begin
      if (a[3:0] == 4'h3) return (!w || ref_idx < 8'd128) ? 4 : 3;
      if (a[3:0] == 4'h8 || a[3:0] == 4'h9) return 1;
      if (a[3:0] >= 4'hD) return 5;
      if (a[3:0] >= 4'hA) return w ? 5 : 3;
      return 3;
    end
    if (ref_map && !w && a >= 16'hFFC0) return 2;
    return 1;
  endfunction

  function automatic logic [6:0] strobes(input int t, input bit w);
    return {t == 1, t == 2, t == 3, t == 4 && !w, t == 4 && w, t == 5 && !w, t == 5 && w};
  endfunction

  function automatic int exp_rd(input logic [15:0] a);
    logic [3:0] tr;
    tr = a[3:0] - 4'hA;
    case (exp_tgt(a, 1'b0))
      1: return ref_mem.exists(int'(a)) ? int'(ref_mem[int'(a)]) : 0;
      2: return int'({2'b10, a[5:0]} ^ 8'h15);
      3: begin
        if (a == 16'h00F2) return int'(ref_idx);
        if (a >= 16'h00F4 && a <= 16'h00F7) return int'(ref_port[a[1:0]]);
        return 0;
      end
      4: return int'({1'b0, ref_idx[6:0]} ^ 8'h5A);
      default: return int'({5'b01100, tr[2:0]});
    endcase
  endfunction

  task automatic access(input bit w, input logic [15:0] a, input logic [7:0] d, input string tag);
    int t;
    logic [3:0] tr;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_rd = !w;
    #1;
    t  = exp_tgt(a, w);
    tr = a[3:0] - 4'hA;
    chk({tag, " R11 selects"}, int'({ram_sel, rom_sel, io_sel, snd_rd, snd_wr, tmr_rd, tmr_wr}),
        int'(strobes(t, w)));
    chk("R4 timer enables", int'(tmr_en), int'(ref_en));
    if (!w) chk({tag, " read data"}, int'(cpu_rdata), exp_rd(a));
    if (t == 1) chk({tag, " ram addr/we"}, int'({ram_we, ram_addr}), int'({w, a}));
    if (t == 2) chk({tag, " rom addr"}, int'(rom_addr), int'(a[5:0]));
    if (t == 4) chk({tag, " snd idx"}, int'(snd_idx), int'(ref_idx[6:0]));
    if (t == 4 && w) chk({tag, " snd wdata"}, int'(snd_wdata), int'(d));
    if (t == 5) chk({tag, " tmr reg"}, int'(tmr_reg), int'(tr[2:0]));
    if (t == 5 && w) chk({tag, " tmr wdata"}, int'(tmr_wdata), int'(d));
    @(posedge clk);
    if (w) begin
      if (t == 1) ref_mem[int'(a)] = d;
      if (a == 16'h00F1) begin
        ref_en  = d[2:0];
        ref_map = d[7];
        if (d[4]) begin ref_port[0] = 8'h00; ref_port[1] = 8'h00; end
        if (d[5]) begin ref_port[2] = 8'h00; ref_port[3] = 8'h00; end
      end
      if (a == 16'h00F2) ref_idx = d;
      if (a >= 16'h00F4 && a <= 16'h00F7) ref_port[a[1:0]] = d;
    end
  endtask

  task automatic idle_chk();
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    #1;
    chk("R11 idle selects", int'({ram_sel, rom_sel, io_sel, snd_rd, snd_wr, tmr_rd, tmr_wr}), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) ext_mem[i] = 8'h00;
    ref_map = 1'b1; ref_en = 3'd0; ref_idx = 8'h00;
    for (int i = 0; i < 4; i++) ref_port[i] = 8'h00;
    cpu_addr = 16'h0; cpu_wdata = 8'h0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10: reset state
    idle_chk();
    access(0, 16'h00F2, 8'h00, "R10 index");
    for (int p = 0; p < 4; p++) access(0, 16'h00F4 + 16'(p), 8'h00, "R10 ports");
    access(0, 16'hFFFE, 8'h00, "R10 R2 rom mapped");

    // R1: plain RAM
    access(1, 16'h0010, 8'h5A, "R1 write");
    access(1, 16'h00EF, 8'hC3, "R1 write top");
    access(1, 16'h00F8, 8'h81, "R1 write F8");
    access(1, 16'h00F9, 8'h42, "R1 write F9");
    access(0, 16'h0010, 8'h00, "R1 read");
    access(0, 16'h00EF, 8'h00, "R1 read top");
    access(0, 16'h00F8, 8'h00, "R1 read F8");
    access(0, 16'h00F9, 8'h00, "R1 read F9");

    // R2/R3: overlay
    access(1, 16'hFFC2, 8'h77, "R3 write under rom");
    access(0, 16'hFFC2, 8'h00, "R2 read rom");
    access(1, 16'h00F1, 8'h83, "R4 ctrl keep map");
    access(0, 16'hFFC0, 8'h00, "R2 still mapped");
    access(1, 16'h00F1, 8'h05, "R4 ctrl unmap");
    access(0, 16'hFFC2, 8'h00, "R3 shadow visible");
    access(0, 16'hFFC0, 8'h00, "R2 unmapped ram");
    access(0, 16'h00F1, 8'h00, "R4 ctrl reads zero");

    // R5: ports and pair clears
    access(1, 16'h00F4, 8'h11, "R5 port");
    access(1, 16'h00F5, 8'h22, "R5 port");
    access(1, 16'h00F6, 8'h33, "R5 port");
    access(1, 16'h00F7, 8'h44, "R5 port");
    for (int p = 0; p < 4; p++) access(0, 16'h00F4 + 16'(p), 8'h00, "R5 port readback");
    access(1, 16'h00F1, 8'h15, "R5 clear low pair");
    for (int p = 0; p < 4; p++) access(0, 16'h00F4 + 16'(p), 8'h00, "R5 after low clear");
    access(1, 16'h00F4, 8'h99, "R5 port");
    access(1, 16'h00F1, 8'h20, "R5 clear high pair");
    for (int p = 0; p < 4; p++) access(0, 16'h00F4 + 16'(p), 8'h00, "R5 after high clear");

    // R8: test register
    access(1, 16'h00F1, 8'h06, "R4 ctrl");
    access(1, 16'h00F0, 8'hFF, "R8 test write");
    access(0, 16'h00F0, 8'h00, "R8 test read");
    access(0, 16'h00F4, 8'h00, "R8 port untouched");
    access(0, 16'h00F2, 8'h00, "R8 index untouched");
    access(0, 16'hFFC2, 8'h00, "R8 map untouched");

    // R6/R7: indirect window
    access(1, 16'h00F2, 8'h05, "R6 index");
    access(0, 16'h00F3, 8'h00, "R6 data read");
    access(1, 16'h00F3, 8'h9A, "R7 data write");
    access(1, 16'h00F2, 8'h7F, "R6 index");
    access(1, 16'h00F3, 8'h3B, "R7 edge 127");
    access(1, 16'h00F2, 8'h80, "R6 index");
    access(1, 16'h00F3, 8'h3C, "R7 edge 128 dropped");
    access(0, 16'h00F3, 8'h00, "R6 masked 128");
    access(1, 16'h00F2, 8'h85, "R6 index");
    access(0, 16'h00F3, 8'h00, "R6 masked read");
    access(1, 16'h00F3, 8'h66, "R7 dropped");
    access(0, 16'h00F2, 8'h00, "R6 index full width");

    // R9: timer page
    for (int r = 10; r < 16; r++) access(1, 16'h00F0 + 16'(r), 8'(r * 3), "R9 timer write");
    for (int r = 10; r < 16; r++) access(0, 16'h00F0 + 16'(r), 8'h00, "R9 timer read");
    idle_chk();

    // R2: remap
    access(1, 16'h00F1, 8'h80, "R4 remap");
    access(0, 16'hFFFF, 8'h00, "R2 remapped");
    access(0, 16'hFFC2, 8'h00, "R2 remapped shadow hidden");
    idle_chk();

    summary();
  end
endmodule